// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block brings a small display panel controller out of deep standby and back into it. Each step is a command for an external 9-bit serial command writer. The sequencer launches one step at a time and waits for the writer to report completion before it moves on. Steps can be a bare command, a command with one data byte, or a command with two data bytes. Some steps are followed by a timed pause. Every step comes from a constant table inside the block: one table for power-up and one for power-down.

Power-up opens with a guarded wake-up prologue of three null commands, each separated by a pause. A write error in this prologue aborts the sequence at once. After the prologue, errors are only gathered, and they are reported when the sequence ends. The backlight comes on only after the final display-on command. Power-down is the mirror image: the backlight goes off first, and then a short shutdown list is sent.

Top module: `pnl_power_seq`

## Requirements
- R1: While reset is high, and at the first clock after it is released, `wr_req`, `backlight_en`, `panel_ready` and `seq_error` are all low and the block idles in the off state.
- R2: A `pwr_on_req` pulse in the off state starts power-up. Positions 0 to 2 of the sequence are the bare command 0x00 (length 0). Each is followed by a pause: the next request appears exactly WAIT_CYCLES+1 cycles after the cycle in which `wr_done` is high. After a step with no pause, the next request appears one cycle after that cycle.
- R3: If `wr_err` comes with the `wr_done` of any of the three wake-up steps, no further request is launched. `seq_error` rises, and `backlight_en` and `panel_ready` stay low.
- R4: Positions 3 to 8 are, in order, with address/length/data:
  - 0xB0/1/0x17
  - 0xBC/1/0x80
  - 0x3B/1/0x00
  - 0xB0/1/0x16
  - 0xB8/2/0xFFF9
  - the bare command 0x11
- R5: Positions 9 to 42 form the register set-up block of one-byte and two-byte writes. Position 22 is 0xBD/1/0x04 (the anti-flicker value in place of the power-on default 0x02). Position 42 is 0xD5/1/0x0E.
- R6: Position 43 is the bare command 0x29, and power-up issues exactly 44 requests. `backlight_en` is low during every power-up request. `backlight_en` and `panel_ready` rise together one cycle after the `wr_done` of the final step.
- R7: An error on any step after the wake-up prologue does not stop the sequence. `seq_error` is raised when the sequence ends.
- R8: A `pwr_off_req` pulse while `panel_ready` is high does the following:
  - `backlight_en` and `panel_ready` drop on the next cycle.
  - One idle cycle later, the block sends 0x28/0, 0xB8/2/0x8002, 0x10/0 and 0xB0/1/0x00, in that order.
  - The block then returns to the off state with both flags low.
- R9: Start and stop pulses are ignored while a sequence runs, and `pwr_on_req` is ignored while the panel is on. `panel_ready` only falls through an accepted `pwr_off_req`.
- R10: `seq_error` holds its value until the next accepted start or stop request, which clears it.
- R11: `wr_req` is a one-cycle strobe. The request fields hold from the strobe until the matching `wr_done`. `wr_len` encodes 0 = bare command, 1 = one byte in `wr_data[7:0]`, and 2 = two bytes, with `wr_data[15:8]` sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_req | input | 1 | Start power-up (taken in off state only) |
| pwr_off_req | input | 1 | Start power-down (taken when panel is on only) |
| wr_req | output | 1 | One-cycle strobe launching a command write |
| wr_addr | output | 8 | Command/register byte |
| wr_len | output | 2 | Payload length: 0, 1 or 2 bytes |
| wr_data | output | 16 | Payload; one byte in [7:0], two bytes high first |
| wr_done | input | 1 | Writer finished the current command |
| wr_err | input | 1 | Writer error, valid with wr_done |
| backlight_en | output | 1 | Backlight enable |
| panel_ready | output | 1 | Panel fully powered and on |
| seq_error | output | 1 | Last sequence hit a write error |

## Verification
On every cycle, the assertions check the following:
- the request strobe is one cycle wide;
- the request fields hold while the writer works;
- the backlight is never on while a command is requested;
- ready implies backlight;
- ready rises only after the display-on command;
- ready holds until a stop request arrives.

Other behaviours are visible only in the bench's scenarios, which capture the whole command log and the cycle gaps:
- the contents and order of both sequences;
- the exact pause length after the wake-up commands;
- the abort on a wake-up error versus the collection of later errors;
- the clearing of the error flag on the next start.

// File: rtl/pnl_seq_pkg.sv
package pnl_seq_pkg;

    localparam int UP_STEPS   = 44;
    localparam int DOWN_STEPS = 4;
    localparam int WAKE_STEPS = 3;
    localparam int IDX_W      = $clog2(UP_STEPS);

    localparam logic [1:0] LEN0 = 2'd0;
    localparam logic [1:0] LEN1 = 2'd1;
    localparam logic [1:0] LEN2 = 2'd2;

    typedef enum logic [2:0] {
        PS_OFF,
        PS_BL_DROP,
        PS_LAUNCH,
        PS_BUSY,
        PS_PAUSE,
        PS_ON
    } pseq_state_e;

    typedef enum logic {
        DIR_UP,
        DIR_DOWN
    } pseq_dir_e;

    typedef struct packed {
        logic [7:0]  addr;
        logic [1:0]  len;
        logic [15:0] data;
        logic        pause;
    } pseq_step_t;

    function automatic pseq_step_t mk(input logic [7:0] a, input logic [1:0] n,
                                      input logic [15:0] d, input logic p);
        pseq_step_t s;
        s.addr  = a;
        s.len   = n;
        s.data  = d;
        s.pause = p;
        return s;
    endfunction

    // Power-up table: wake-up prologue, power rails, set-up block, display on.
    function automatic pseq_step_t up_step(input logic [IDX_W-1:0] i);
        case (i)
            6'd0, 6'd1, 6'd2: return mk(8'h00, LEN0, 16'h0000, 1'b1);
            6'd3:  return mk(8'hB0, LEN1, 16'h0017, 1'b0);
            6'd4:  return mk(8'hBC, LEN1, 16'h0080, 1'b0);
            6'd5:  return mk(8'h3B, LEN1, 16'h0000, 1'b0);
            6'd6:  return mk(8'hB0, LEN1, 16'h0016, 1'b0);
            6'd7:  return mk(8'hB8, LEN2, 16'hFFF9, 1'b0);
            6'd8:  return mk(8'h11, LEN0, 16'h0000, 1'b0);
            6'd9:  return mk(8'hBA, LEN1, 16'h0001, 1'b0);
            6'd10: return mk(8'hBB, LEN1, 16'h0000, 1'b0);
            6'd11: return mk(8'h3A, LEN1, 16'h0060, 1'b0);
            6'd12: return mk(8'hBF, LEN1, 16'h0010, 1'b0);
            6'd13: return mk(8'hB1, LEN1, 16'h0056, 1'b0);
            6'd14: return mk(8'hB2, LEN1, 16'h0033, 1'b0);
            6'd15: return mk(8'hB3, LEN1, 16'h0011, 1'b0);
            6'd16: return mk(8'hB3, LEN1, 16'h0011, 1'b0);
            6'd17: return mk(8'hB4, LEN1, 16'h0002, 1'b0);
            6'd18: return mk(8'hB5, LEN1, 16'h002B, 1'b0);
            6'd19: return mk(8'hB6, LEN1, 16'h0040, 1'b0);
            6'd20: return mk(8'hB7, LEN1, 16'h0003, 1'b0);
            6'd21: return mk(8'hB9, LEN1, 16'h0004, 1'b0);
            6'd22: return mk(8'hBD, LEN1, 16'h0004, 1'b0);
            6'd23: return mk(8'hBE, LEN1, 16'h0000, 1'b0);
            6'd24: return mk(8'hC0, LEN1, 16'h0011, 1'b0);
            6'd25: return mk(8'hC1, LEN1, 16'h0011, 1'b0);
            6'd26: return mk(8'hC2, LEN1, 16'h0011, 1'b0);
            6'd27: return mk(8'hC3, LEN2, 16'h2040, 1'b0);
            6'd28: return mk(8'hC4, LEN2, 16'h60C0, 1'b0);
            6'd29: return mk(8'hC5, LEN2, 16'h1020, 1'b0);
            6'd30: return mk(8'hC6, LEN2, 16'h60C0, 1'b0);
            6'd31: return mk(8'hC7, LEN2, 16'h5533, 1'b0);
            6'd32: return mk(8'hC8, LEN1, 16'h0000, 1'b0);
            6'd33: return mk(8'hC9, LEN1, 16'h0000, 1'b0);
            6'd34: return mk(8'hCA, LEN1, 16'h0000, 1'b0);
            6'd35: return mk(8'hEC, LEN2, 16'h01F0, 1'b0);
            6'd36: return mk(8'hCF, LEN1, 16'h0002, 1'b0);
            6'd37: return mk(8'hD0, LEN2, 16'h0804, 1'b0);
            6'd38: return mk(8'hD1, LEN1, 16'h0001, 1'b0);
            6'd39: return mk(8'hD2, LEN2, 16'h0000, 1'b0);
            6'd40: return mk(8'hD3, LEN2, 16'h0D0E, 1'b0);
            6'd41: return mk(8'hD4, LEN2, 16'h11A4, 1'b0);
            6'd42: return mk(8'hD5, LEN1, 16'h000E, 1'b0);
            6'd43: return mk(8'h29, LEN0, 16'h0000, 1'b0);
            default: return mk(8'h00, LEN0, 16'h0000, 1'b0);
        endcase
    endfunction

    // Power-down table: display off, outputs parked, sleep, rails off.
    function automatic pseq_step_t down_step(input logic [IDX_W-1:0] i);
        case (i)
            6'd0: return mk(8'h28, LEN0, 16'h0000, 1'b0);
            6'd1: return mk(8'hB8, LEN2, 16'h8002, 1'b0);
            6'd2: return mk(8'h10, LEN0, 16'h0000, 1'b0);
            6'd3: return mk(8'hB0, LEN1, 16'h0000, 1'b0);
            default: return mk(8'h00, LEN0, 16'h0000, 1'b0);
        endcase
    endfunction

endpackage

// File: rtl/pnl_seq_rom.sv
module pnl_seq_rom
    import pnl_seq_pkg::*;
(
    input  pseq_dir_e        dir,
    input  logic [IDX_W-1:0] idx,
    output pseq_step_t       step,
    output logic             last,
    output logic             wake
);
    localparam logic [IDX_W-1:0] UP_LAST   = IDX_W'(UP_STEPS - 1);
    localparam logic [IDX_W-1:0] DOWN_LAST = IDX_W'(DOWN_STEPS - 1);
    localparam logic [IDX_W-1:0] WAKE_END  = IDX_W'(WAKE_STEPS);

    always_comb begin
        if (dir == DIR_UP) begin
            step = up_step(idx);
            last = (idx == UP_LAST);
            wake = (idx < WAKE_END);
        end else begin
            step = down_step(idx);
            last = (idx == DOWN_LAST);
            wake = 1'b0;
        end
    end
endmodule

// File: rtl/pnl_seq_timer.sv
module pnl_seq_timer #(
    parameter int WAIT_CYCLES = 150_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             running;

    assign expired = running && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= LOAD;
            running <= 1'b1;
        end else if (expired) begin
            running <= 1'b0;
        end else if (running) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/pnl_seq_ctrl.sv
module pnl_seq_ctrl
    import pnl_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             on_req,
    input  logic             off_req,
    input  logic             wr_done,
    input  logic             wr_err,
    input  logic             step_pause,
    input  logic             step_last,
    input  logic             step_wake,
    input  logic             tmr_expired,
    output logic             tmr_start,
    output pseq_dir_e        dir,
    output logic [IDX_W-1:0] idx,
    output logic             wr_req,
    output logic             ready,
    output logic             backlight,
    output logic             seq_error
);
    pseq_state_e      st, st_n;
    pseq_dir_e        dir_n;
    logic [IDX_W-1:0] idx_n;
    logic             acc, acc_n, acc_now;
    logic             err_n, bl_n, advance;

    always_comb begin
        st_n      = st;
        dir_n     = dir;
        idx_n     = idx;
        acc_n     = acc;
        acc_now   = acc;
        err_n     = seq_error;
        bl_n      = backlight;
        tmr_start = 1'b0;
        advance   = 1'b0;
        case (st)
            PS_OFF: if (on_req) begin
                st_n  = PS_LAUNCH;
                dir_n = DIR_UP;
                idx_n = '0;
                acc_n = 1'b0;
                err_n = 1'b0;
            end
            PS_ON: if (off_req) begin
                st_n  = PS_BL_DROP;
                dir_n = DIR_DOWN;
                idx_n = '0;
                acc_n = 1'b0;
                err_n = 1'b0;
                bl_n  = 1'b0;
            end
            PS_BL_DROP: st_n = PS_LAUNCH;
            PS_LAUNCH:  st_n = PS_BUSY;
            PS_BUSY: if (wr_done) begin
                acc_now = acc | wr_err;
                acc_n   = acc_now;
                if (wr_err && step_wake) begin
                    st_n  = PS_OFF;
                    err_n = 1'b1;
                end else if (step_pause) begin
                    st_n      = PS_PAUSE;
                    tmr_start = 1'b1;
                end else begin
                    advance = 1'b1;
                end
            end
            PS_PAUSE: if (tmr_expired) advance = 1'b1;
            default: st_n = PS_OFF;
        endcase

        if (advance) begin
            if (step_last) begin
                err_n = acc_now;
                if (dir == DIR_UP) begin
                    st_n = PS_ON;
                    bl_n = 1'b1;
                end else begin
                    st_n = PS_OFF;
                end
            end else begin
                idx_n = idx + 1'b1;
                st_n  = PS_LAUNCH;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PS_OFF;
            dir       <= DIR_UP;
            idx       <= '0;
            acc       <= 1'b0;
            seq_error <= 1'b0;
            backlight <= 1'b0;
        end else begin
            st        <= st_n;
            dir       <= dir_n;
            idx       <= idx_n;
            acc       <= acc_n;
            seq_error <= err_n;
            backlight <= bl_n;
        end
    end

    assign wr_req = (st == PS_LAUNCH);
    assign ready  = (st == PS_ON);
endmodule

// File: rtl/pnl_power_seq.sv
module pnl_power_seq
    import pnl_seq_pkg::*;
#(
    parameter int WAIT_CYCLES = 150_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_on_req,
    input  logic        pwr_off_req,
    output logic        wr_req,
    output logic [7:0]  wr_addr,
    output logic [1:0]  wr_len,
    output logic [15:0] wr_data,
    input  logic        wr_done,
    input  logic        wr_err,
    output logic        backlight_en,
    output logic        panel_ready,
    output logic        seq_error
);
    pseq_dir_e        dir;
    logic [IDX_W-1:0] idx;
    pseq_step_t       step;
    logic             step_last, step_wake;
    logic             tmr_start, tmr_expired;

    pnl_seq_rom u_rom (
        .dir  (dir),
        .idx  (idx),
        .step (step),
        .last (step_last),
        .wake (step_wake)
    );

    pnl_seq_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    pnl_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .on_req      (pwr_on_req),
        .off_req     (pwr_off_req),
        .wr_done     (wr_done),
        .wr_err      (wr_err),
        .step_pause  (step.pause),
        .step_last   (step_last),
        .step_wake   (step_wake),
        .tmr_expired (tmr_expired),
        .tmr_start   (tmr_start),
        .dir         (dir),
        .idx         (idx),
        .wr_req      (wr_req),
        .ready       (panel_ready),
        .backlight   (backlight_en),
        .seq_error   (seq_error)
    );

    assign wr_addr = step.addr;
    assign wr_len  = step.len;
    assign wr_data = step.data;
endmodule

// File: rtl/pnl_power_seq_chk.sv
module pnl_power_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        pwr_off_req,
    input logic        wr_req,
    input logic [7:0]  wr_addr,
    input logic [1:0]  wr_len,
    input logic [15:0] wr_data,
    input logic        backlight_en,
    input logic        panel_ready
);
    // R11: launch is a single-cycle strobe
    a_r11_req_strobe: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> !wr_req);

    // R11: fields hold after the strobe while the writer works
    a_r11_fields_stable: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> ($stable(wr_addr) && $stable(wr_len) && $stable(wr_data)));

    // R6 / R8: no command is requested with the backlight lit
    a_r8_bl_no_req: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> !backlight_en);

    // R6: a ready panel always has its backlight on
    a_r6_ready_bl: assert property (@(posedge clk) disable iff (rst)
        panel_ready |-> backlight_en);

    // R6: ready rises only after the display-on command
    a_r6_ready_after_on: assert property (@(posedge clk) disable iff (rst)
        $rose(panel_ready) |-> ($past(wr_addr) == 8'h29));

    // R9: only a stop request takes the panel out of ready
    a_r9_ready_hold: assert property (@(posedge clk) disable iff (rst)
        (panel_ready && !pwr_off_req) |=> panel_ready);
endmodule

bind pnl_power_seq pnl_power_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pwr_off_req  (pwr_off_req),
    .wr_req       (wr_req),
    .wr_addr      (wr_addr),
    .wr_len       (wr_len),
    .wr_data      (wr_data),
    .backlight_en (backlight_en),
    .panel_ready  (panel_ready)
);

// File: tb/tb_pnl_power_seq.sv
`timescale 1ns/1ps
module tb_pnl_power_seq;
    localparam int W   = 20;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_on_req = 1'b0, pwr_off_req = 1'b0;
    logic wr_req, wr_done, wr_err;
    logic [7:0]  wr_addr;
    logic [1:0]  wr_len;
    logic [15:0] wr_data;
    logic backlight_en, panel_ready, seq_error;

    always #5 clk = ~clk;

    pnl_power_seq #(.WAIT_CYCLES(W)) dut (
        .clk(clk), .rst(rst), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
        .wr_done(wr_done), .wr_err(wr_err), .backlight_en(backlight_en),
        .panel_ready(panel_ready), .seq_error(seq_error)
    );

    int checks = 0, fails = 0, cyc = 0, n_log = 0, err_at = -1, last_done = 0;
    logic        finished = 1'b0;
    logic [7:0]  lg_addr [0:63];
    logic [1:0]  lg_len  [0:63];
    logic [15:0] lg_data [0:63];
    logic        lg_bl   [0:63];
    int          lg_gap  [0:63];

    // {position, addr, len, data} expected in the power-up log
    localparam logic [33:0] EXP_UP [0:11] = '{
        {8'd0,  8'h00, 2'd0, 16'h0000}, {8'd1,  8'h00, 2'd0, 16'h0000},
        {8'd2,  8'h00, 2'd0, 16'h0000}, {8'd3,  8'hB0, 2'd1, 16'h0017},
        {8'd4,  8'hBC, 2'd1, 16'h0080}, {8'd5,  8'h3B, 2'd1, 16'h0000},
        {8'd6,  8'hB0, 2'd1, 16'h0016}, {8'd7,  8'hB8, 2'd2, 16'hFFF9},
        {8'd8,  8'h11, 2'd0, 16'h0000}, {8'd22, 8'hBD, 2'd1, 16'h0004},
        {8'd42, 8'hD5, 2'd1, 16'h000E}, {8'd43, 8'h29, 2'd0, 16'h0000}
    };
    localparam logic [25:0] EXP_DN [0:3] = '{
        {8'h28, 2'd0, 16'h0000}, {8'hB8, 2'd2, 16'h8002},
        {8'h10, 2'd0, 16'h0000}, {8'hB0, 2'd1, 16'h0000}
    };

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Writer model: logs each strobe, answers done LAT cycles later
    initial begin
        int cnt, cur;
        cnt = 0; cur = 0;
        wr_done = 1'b0; wr_err = 1'b0;
        forever begin
            @(posedge clk); #1;
            wr_done = 1'b0; wr_err = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    wr_done = 1'b1;
                    wr_err = (cur == err_at);
                    last_done = cyc;
                end
            end
            if (wr_req) begin
                cur = n_log;
                if (n_log < 64) begin
                    lg_addr[n_log] = wr_addr;
                    lg_len[n_log]  = wr_len;
                    lg_data[n_log] = wr_data;
                    lg_bl[n_log]   = backlight_en;
                    lg_gap[n_log]  = cyc - last_done;
                end
                n_log++;
                cnt = LAT;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic pulse_on();
        @(posedge clk); #1 pwr_on_req = 1'b1;
        @(posedge clk); #1 pwr_on_req = 1'b0;
    endtask

    task automatic pulse_off();
        @(posedge clk); #1 pwr_off_req = 1'b1;
        @(posedge clk); #1 pwr_off_req = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        chk("R1 req", wr_req, 0);
        chk("R1 backlight", backlight_en, 0);
        chk("R1 ready", panel_ready, 0);
        #1 rst = 1'b0;
        wait_cyc(1);
        chk("R1 error", seq_error, 0);
        chk("R1 ready after release", panel_ready, 0);

        // Normal power-up; a stop pulse mid-way is ignored (R9)
        n_log = 0;
        pulse_on();
        wait_cyc(30);
        pulse_off();
        wait_cyc(600);
        for (int k = 0; k < 12; k++) begin
            int p;
            p = int'(EXP_UP[k][33:26]);
            chk($sformatf("R4/R5/R2 addr at %0d", p), lg_addr[p], int'(EXP_UP[k][25:18]));
            chk($sformatf("R11 len at %0d", p), lg_len[p], int'(EXP_UP[k][17:16]));
            chk($sformatf("R4/R5 data at %0d", p), lg_data[p], int'(EXP_UP[k][15:0]));
        end
        chk("R2 pause after wake 0", lg_gap[1], W + 1);
        chk("R2 pause after wake 1", lg_gap[2], W + 1);
        chk("R2 pause after wake 2", lg_gap[3], W + 1);
        chk("R2 no pause after step 3", lg_gap[4], 1);
        chk("R6 request count", n_log, 44);
        chk("R6 backlight low at display-on", lg_bl[43], 0);
        chk("R6 backlight", backlight_en, 1);
        chk("R9 ready despite stop pulse", panel_ready, 1);
        chk("R7 no error", seq_error, 0);

        // Start pulse while on is ignored
        pulse_on();
        wait_cyc(20);
        chk("R9 no request on redundant start", n_log, 44);
        chk("R9 still ready", panel_ready, 1);

        // Power-down; a start pulse during it is ignored
        n_log = 0;
        pulse_off();
        #2;
        chk("R8 backlight drops first", backlight_en, 0);
        chk("R8 ready drops", panel_ready, 0);
        chk("R8 no request yet", wr_req, 0);
        wait_cyc(3);
        pulse_on();
        wait_cyc(100);
        chk("R8/R9 down count", n_log, 4);
        for (int k = 0; k < 4; k++) begin
            chk($sformatf("R8 addr %0d", k), lg_addr[k], int'(EXP_DN[k][25:18]));
            chk($sformatf("R8 len %0d", k), lg_len[k], int'(EXP_DN[k][17:16]));
            chk($sformatf("R8 data %0d", k), lg_data[k], int'(EXP_DN[k][15:0]));
            chk($sformatf("R8 backlight off %0d", k), lg_bl[k], 0);
        end
        chk("R8 off ready", panel_ready, 0);

        // Error after the prologue is collected
        n_log = 0; err_at = 10;
        pulse_on();
        wait_cyc(600);
        chk("R7 count despite error", n_log, 44);
        chk("R7 error reported", seq_error, 1);
        chk("R7 ready", panel_ready, 1);

        // Stop clears the error flag
        n_log = 0; err_at = -1;
        pulse_off();
        wait_cyc(2);
        chk("R10 error cleared on stop", seq_error, 0);
        wait_cyc(100);

        // Wake-up error aborts
        n_log = 0; err_at = 1;
        pulse_on();
        wait_cyc(200);
        chk("R3 abort count", n_log, 2);
        chk("R3 error", seq_error, 1);
        chk("R3 backlight", backlight_en, 0);
        chk("R3 ready", panel_ready, 0);

        // Next start clears the error and completes
        n_log = 0; err_at = -1;
        pulse_on();
        wait_cyc(2);
        chk("R10 error cleared on start", seq_error, 0);
        wait_cyc(600);
        chk("R10 restart count", n_log, 44);
        chk("R10 restart ready", panel_ready, 1);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule